// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block takes the receive side of one TDM serial link and hands each byte slot of a frame to one of five serial channel controllers, or drops it. Routing is held as a list of 16-bit entries in a routing RAM shared by four TDMs and both directions. Each entry names one destination channel and a run of one to eight consecutive byte slots. The block starts walking the list when it sees a frame sync, shifts in serial bits, and at the end of each byte raises a one-cycle strobe carrying the byte and the channel number. When the entry flagged as final has been used up, it parks on the start of its list and ignores further bits until the next frame sync.

Serial bits arrive as single-cycle qualifiers (`bit_vld`) in the system clock domain. A 16-bit mode word picks where the list sits in the RAM, the frame-sync polarity and a sync-to-data delay. A 4-bit global enable byte gates the TDM, and the parameter `TDM_INDEX` picks its bit. After reset the block spends `RAM_DEPTH` cycles filling the whole RAM with "final entry, unused channel" words. Table writes made during that sweep are lost.

Top module: `tdm_slot_router`

## Requirements
- R1: Right after reset `slot_vld` and `sync_err` are 0.
- R2: After the reset sweep every RAM word is 0x0001 (final flag only). An enabled TDM whose list was never written raises no strobe for any frame.
- R3: An entry holds the final flag in bit 0, the byte-resolution flag in bit 1 (not interpreted), the run length minus one in bits 4:2 and the channel code in bits 8:5. Bytes are assembled with the first received bit as the MSB.
- R4: Channel code 0x9, 0xA, 0xB, 0xC and 0x1 map to `slot_chan` 1, 2, 3, 4 and 5. Code 0 and every other code drop the slot, so no strobe is raised for it.
- R5: Entries are used in address order, so a run longer than eight slots is written as several entries for the same channel. After the final-flagged entry, bits are ignored until the next frame sync.
- R6: The list starts at entry `RAM_DEPTH/2 + 32*mode_word[15:12]` (receive half). Words in the transmit half have no effect.
- R7: `mode_word[5]`=1 makes the frame sync active-low. A sync event is the first `bit_vld` at which the sync is at its active level after a `bit_vld` at which it was inactive.
- R8: With `mode_word[9:8]`=D, slot 0 begins with the bit D `bit_vld` pulses after the sync event. With D=0, the bit sampled with the sync event is the first bit of slot 0.
- R9: When `glb_en[TDM_INDEX]` is 0 no strobe is raised and any walk in progress is dropped.
- R10: A sync event that arrives before the final entry is used up restarts the walk at the list start and sets `sync_err`. `sync_err` stays set until reset.
- R11: `slot_vld` is high for exactly the one cycle after the clock edge that samples the eighth bit of a routed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Qualifies one serial bit on `ser_d` |
| ser_d | input | 1 | Serial receive data |
| fsync | input | 1 | Frame sync, sampled with `bit_vld` |
| mode_word | input | 16 | TDM mode: start block, sync delay, sync polarity |
| glb_en | input | TDM_COUNT | Per-TDM enable bits |
| tbl_we | input | 1 | Routing RAM write strobe |
| tbl_addr | input | AW | Routing RAM write address |
| tbl_wdata | input | 16 | Routing entry to write |
| slot_vld | output | 1 | One-cycle strobe for a routed byte |
| slot_byte | output | 8 | Received byte |
| slot_chan | output | 3 | Destination channel 1..5 |
| sync_err | output | 1 | Sticky early-frame-sync flag |

## Verification
The assertions assume that `bit_vld` is never high in two of any three consecutive cycles. The synchronous RAM read needs that gap to present a new entry before the next bit, and the single-cycle strobe check depends on it. The stimulus drives one bit every four clocks and changes the mode word and the tables only between frames. Random tables use start blocks that are multiples of four, so a list of up to ten entries stays inside its quarter of the receive half. Random frames mix valid, unused and unmapped channel codes with random delays and polarities. Directed cases cover the empty table, split runs, the transmit-half decoy, the disabled TDM, an early sync and the exact strobe cycle.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } walk_st_t;

  typedef struct packed {
    logic [6:0] rsvd;
    logic [3:0] code;
    logic [2:0] len_m1;
    logic       byte_res;
    logic       last;
  } route_ent_t;

  function automatic logic [2:0] code_to_chan(input logic [3:0] c);
    case (c)
      4'h9:    return 3'd1;
      4'hA:    return 3'd2;
      4'hB:    return 3'd3;
      4'hC:    return 3'd4;
      4'h1:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/tsr_route_ram.sv
module tsr_route_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic          busy
);
  localparam logic [W-1:0] CLR_WORD = W'(1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] clr_cnt;
  logic          we;
  logic [AW-1:0] wa;
  logic [W-1:0]  wd;

  // reset sweep: every word becomes "final entry, unused channel" (R2)
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b1;
      clr_cnt <= '0;
    end else if (busy) begin
      clr_cnt <= clr_cnt + AW'(1);
      if (clr_cnt == AW'(DEPTH - 1)) busy <= 1'b0;
    end
  end

  assign we = busy | wr_en;
  assign wa = busy ? clr_cnt : wr_addr;
  assign wd = busy ? CLR_WORD : wr_data;

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tsr_sync_det.sv
module tsr_sync_det (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic fsync,
  input  logic active_low,
  output logic sync_evt
);
  logic lvl;
  logic prev_lvl;

  assign lvl = fsync ^ active_low;

  always_ff @(posedge clk) begin
    if (rst)          prev_lvl <= 1'b0;
    else if (bit_vld) prev_lvl <= lvl;
  end

  // first active sample after an inactive one (R7)
  assign sync_evt = bit_vld & lvl & ~prev_lvl;
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker
  import tsr_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          bit_vld,
  input  logic          ser_d,
  input  logic          sync_evt,
  input  logic [1:0]    dly,
  input  logic [AW-1:0] base_addr,
  input  route_ent_t    ent,
  output logic [AW-1:0] rd_addr,
  output logic          out_vld,
  output logic [7:0]    out_byte,
  output logic [2:0]    out_chan,
  output logic          sync_err
);
  walk_st_t      st;
  logic [AW-1:0] ptr;
  logic [1:0]    dcnt;
  logic [2:0]    bitcnt;
  logic [2:0]    slot;
  logic [6:0]    shreg;
  logic [2:0]    chan_num;
  logic          unused_ent;

  assign rd_addr    = ptr;
  assign chan_num   = code_to_chan(ent.code);
  assign unused_ent = ^{ent.rsvd, ent.byte_res};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      dcnt     <= '0;
      bitcnt   <= '0;
      slot     <= '0;
      shreg    <= '0;
      out_vld  <= 1'b0;
      out_byte <= '0;
      out_chan <= '0;
      sync_err <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      if (!active) begin
        st <= ST_IDLE;
      end else if (bit_vld) begin
        if (sync_evt) begin
          if (st != ST_IDLE) sync_err <= 1'b1;  // early sync (R10)
          ptr  <= base_addr;
          slot <= '0;
          if (dly == 2'd0) begin
            st     <= ST_RUN;
            shreg  <= {6'd0, ser_d};
            bitcnt <= 3'd1;
          end else begin
            st     <= ST_DELAY;
            dcnt   <= dly;
            bitcnt <= 3'd0;
          end
        end else begin
          case (st)
            ST_DELAY: begin
              if (dcnt == 2'd1) begin
                st     <= ST_RUN;
                shreg  <= {6'd0, ser_d};
                bitcnt <= 3'd1;
              end else begin
                dcnt <= dcnt - 2'd1;
              end
            end
            ST_RUN: begin
              if (bitcnt == 3'd7) begin
                bitcnt <= 3'd0;
                if (chan_num != 3'd0) begin
                  out_vld  <= 1'b1;
                  out_byte <= {shreg, ser_d};
                  out_chan <= chan_num;
                end
                if (slot == ent.len_m1) begin
                  slot <= '0;
                  if (ent.last) begin
                    st  <= ST_IDLE;
                    ptr <= base_addr;
                  end else begin
                    ptr <= ptr + AW'(1);
                  end
                end else begin
                  slot <= slot + 3'd1;
                end
              end else begin
                shreg  <= {shreg[5:0], ser_d};
                bitcnt <= bitcnt + 3'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R9: a strobe only follows a cycle in which the TDM was active
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(active));

  // R4: strobed channel is always one of the five mapped channels
  a_r4_chan_range: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_chan >= 3'd1 && out_chan <= 3'd5));

  // R11: a strobe follows a sampled bit and lasts one cycle
  a_r11_after_bit: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(bit_vld));
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);

  // R11: input spacing the synchronous table read relies on
  a_r11_bit_gap: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> ##1 !bit_vld ##1 !bit_vld);

  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    sync_err |=> sync_err);
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tsr_pkg::*;
#(
  parameter int RAM_DEPTH = 1024,
  parameter int ENT_W     = 16,
  parameter int TDM_COUNT = 4,
  parameter int TDM_INDEX = 0,
  parameter int RX_DIR    = 1,
  parameter int BLK_ENT   = 32,
  localparam int AW       = $clog2(RAM_DEPTH),
  localparam int HALF     = RAM_DEPTH / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_vld,
  input  logic                 ser_d,
  input  logic                 fsync,
  input  logic [15:0]          mode_word,
  input  logic [TDM_COUNT-1:0] glb_en,
  input  logic                 tbl_we,
  input  logic [AW-1:0]        tbl_addr,
  input  logic [ENT_W-1:0]     tbl_wdata,
  output logic                 slot_vld,
  output logic [7:0]           slot_byte,
  output logic [2:0]           slot_chan,
  output logic                 sync_err
);
  logic [AW-1:0]    base_addr;
  logic [AW-1:0]    rd_addr;
  logic [ENT_W-1:0] rd_data;
  logic             ram_busy;
  logic             sync_evt;
  logic             active;
  route_ent_t       ent;
  logic             unused_mode;

  assign base_addr = AW'(RX_DIR * HALF) + AW'(BLK_ENT) * AW'(mode_word[15:12]);
  assign active    = glb_en[TDM_INDEX] & ~ram_busy;
  assign ent       = route_ent_t'(rd_data);
  assign unused_mode = ^{mode_word[11:10], mode_word[7:6], mode_word[4:0], glb_en};

  tsr_route_ram #(.DEPTH(RAM_DEPTH), .W(ENT_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .busy    (ram_busy)
  );

  tsr_sync_det u_sync (
    .clk        (clk),
    .rst        (rst),
    .bit_vld    (bit_vld),
    .fsync      (fsync),
    .active_low (mode_word[5]),
    .sync_evt   (sync_evt)
  );

  tsr_walker #(.AW(AW)) u_walk (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .bit_vld   (bit_vld),
    .ser_d     (ser_d),
    .sync_evt  (sync_evt),
    .dly       (mode_word[9:8]),
    .base_addr (base_addr),
    .ent       (ent),
    .rd_addr   (rd_addr),
    .out_vld   (slot_vld),
    .out_byte  (slot_byte),
    .out_chan  (slot_chan),
    .sync_err  (sync_err)
  );
endmodule

// File: tb/tdm_slot_router_test.sv
module tdm_slot_router_test;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, bit_vld = 1'b0, ser_d = 1'b0, fsync = 1'b0;
  logic [15:0] mode_word = '0;
  logic [3:0]  glb_en = '0;
  logic        tbl_we = 1'b0;
  logic [AW-1:0] tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic        slot_vld, sync_err;
  logic [7:0]  slot_byte;
  logic [2:0]  slot_chan;

  tdm_slot_router #(.RAM_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .ser_d(ser_d), .fsync(fsync),
    .mode_word(mode_word), .glb_en(glb_en), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .slot_vld(slot_vld), .slot_byte(slot_byte),
    .slot_chan(slot_chan), .sync_err(sync_err)
  );

  int n_chk = 0, n_bad = 0;
  logic cur_pol = 1'b0;
  logic [15:0] shadow [0:127];
  logic [7:0]  fb [0:63];
  logic [7:0]  cap_b [0:255];
  logic [2:0]  cap_c [0:255];
  logic [7:0]  exp_b [0:255];
  logic [2:0]  exp_c [0:255];
  int cap_n = 0, exp_n = 0;

  function automatic logic [2:0] ch_of(input logic [3:0] c);
    case (c)
      4'h9: return 3'd1;
      4'hA: return 3'd2;
      4'hB: return 3'd3;
      4'hC: return 3'd4;
      4'h1: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [15:0] mk_ent(input logic [3:0] c, input logic [2:0] l, input logic last);
    return {7'd0, c, l, 1'b1, last};
  endfunction

  task automatic check_int(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk)
    if (slot_vld && cap_n < 256) begin
      cap_b[cap_n] = slot_byte;
      cap_c[cap_n] = slot_chan;
      cap_n++;
    end

  task automatic set_mode(input int sad, input int dly, input logic pol);
    @(negedge clk);
    mode_word = {4'(sad), 2'b00, 2'(dly), 2'b00, pol, 5'd0};
    cur_pol = pol;
    fsync = pol;
  endtask

  task automatic write_ent(input int addr, input logic [15:0] w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = AW'(addr); tbl_wdata = w;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_rx(input int sad, input int n);
    for (int i = 0; i < n; i++) write_ent(HALF + sad * 32 + i, shadow[i]);
  endtask

  task automatic put_bit(input logic fs, input logic d);
    @(negedge clk);
    bit_vld = 1'b1; fsync = fs ^ cur_pol; ser_d = d;
    @(negedge clk);
    bit_vld = 1'b0; fsync = cur_pol;
    @(negedge clk);
    @(negedge clk);
  endtask

  // builds expectation from the shadow table, sends one frame, compares
  task automatic run_frame(input string req, input int dly, input int nbytes, input bit none);
    int e, s, len;
    logic [15:0] w;
    logic [2:0] c;
    logic d;
    exp_n = 0;
    if (!none) begin
      e = 0; s = 0;
      while (s < nbytes && e < 128) begin
        w = shadow[e];
        len = int'(w[4:2]) + 1;
        for (int k = 0; k < len; k++)
          if (s < nbytes) begin
            c = ch_of(w[8:5]);
            if (c != 3'd0) begin exp_b[exp_n] = fb[s]; exp_c[exp_n] = c; exp_n++; end
            s++;
          end
        if (w[0]) break;
        e++;
      end
    end
    @(negedge clk);
    cap_n = 0;
    for (int j = 0; j < dly + 8 * nbytes; j++) begin
      if (j < dly) d = 1'($urandom);
      else d = fb[(j - dly) / 8][7 - ((j - dly) % 8)];
      put_bit(j == 0, d);
    end
    repeat (6) @(negedge clk);
    check_int(req, "strobe count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check_int(req, "byte", int'(cap_b[i]), int'(exp_b[i]));
      check_int(req, "channel", int'(cap_c[i]), int'(exp_c[i]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n_ent, tot, sad;
    logic [3:0] codes [0:6];
    void'($urandom(32'd4242));
    codes[0] = 4'h0; codes[1] = 4'h1; codes[2] = 4'h9; codes[3] = 4'hA;
    codes[4] = 4'hB; codes[5] = 4'hC; codes[6] = 4'h3;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_int("R1", "slot_vld after reset", int'(slot_vld), 0);
    check_int("R1", "sync_err after reset", int'(sync_err), 0);
    repeat (DEPTH + 20) @(negedge clk);

    // R2: untouched table routes nothing
    glb_en = 4'b0001;
    set_mode(0, 0, 1'b0);
    for (int i = 0; i < 128; i++) shadow[i] = 16'h0001;
    for (int i = 0; i < 6; i++) fb[i] = 8'($urandom);
    run_frame("R2", 0, 6, 1'b0);

    // R3 R4 R5: mixed entries, unmapped code dropped, bits after final ignored
    shadow[0] = mk_ent(4'h9, 3'd2, 1'b0);
    shadow[1] = mk_ent(4'h0, 3'd1, 1'b0);
    shadow[2] = mk_ent(4'h3, 3'd0, 1'b0);
    shadow[3] = mk_ent(4'h1, 3'd0, 1'b1);
    load_rx(0, 4);
    fb[0] = 8'hA5; fb[1] = 8'h3C; fb[2] = 8'h81; fb[3] = 8'h00;
    fb[4] = 8'hFF; fb[5] = 8'h12; fb[6] = 8'hC3; fb[7] = 8'h77; fb[8] = 8'h99;
    run_frame("R3", 0, 9, 1'b0);
    check_int("R4", "code 0x1 maps to channel 5", int'(cap_c[3]), 5);
    check_int("R3", "first byte MSB first", int'(cap_b[0]), 8'hA5);

    // R5: 12-slot run split over two entries
    shadow[0] = mk_ent(4'hB, 3'd7, 1'b0);
    shadow[1] = mk_ent(4'hB, 3'd3, 1'b1);
    load_rx(0, 2);
    for (int i = 0; i < 14; i++) fb[i] = 8'($urandom);
    run_frame("R5", 0, 14, 1'b0);

    // R6: start block 4, transmit-half decoy at the same offset
    shadow[0] = mk_ent(4'hA, 3'd1, 1'b1);
    load_rx(4, 1);
    write_ent(4 * 32, mk_ent(4'h9, 3'd1, 1'b1));
    set_mode(4, 0, 1'b0);
    for (int i = 0; i < 3; i++) fb[i] = 8'($urandom);
    run_frame("R6", 0, 3, 1'b0);
    check_int("R6", "receive-half channel", int'(cap_c[0]), 2);

    // R8: sync delay
    set_mode(4, 2, 1'b0);
    run_frame("R8", 2, 3, 1'b0);
    set_mode(4, 3, 1'b0);
    run_frame("R8", 3, 3, 1'b0);

    // R7: active-low sync
    set_mode(4, 1, 1'b1);
    run_frame("R7", 1, 3, 1'b0);

    // R9: disabled TDM
    glb_en = 4'b1110;
    set_mode(4, 0, 1'b0);
    run_frame("R9", 0, 3, 1'b1);
    glb_en = 4'b0001;

    // R10: early sync restarts the walk and sets the sticky flag
    check_int("R10", "sync_err before early sync", int'(sync_err), 0);
    shadow[0] = mk_ent(4'h9, 3'd5, 1'b1);
    load_rx(0, 1);
    set_mode(0, 0, 1'b0);
    for (int i = 0; i < 6; i++) fb[i] = 8'($urandom);
    run_frame("R10", 0, 3, 1'b0);
    check_int("R10", "sync_err after partial frame", int'(sync_err), 0);
    run_frame("R10", 0, 6, 1'b0);
    check_int("R10", "sync_err after early sync", int'(sync_err), 1);
    run_frame("R10", 0, 6, 1'b0);
    check_int("R10", "sync_err stays set", int'(sync_err), 1);

    // R11: exact strobe cycle for a single-slot table
    shadow[0] = mk_ent(4'hC, 3'd0, 1'b1);
    load_rx(0, 1);
    for (int j = 0; j < 7; j++) put_bit(j == 0, 1'(8'h5A >> (7 - j)));
    @(negedge clk);
    bit_vld = 1'b1; ser_d = 1'b0;
    check_int("R11", "no strobe before eighth bit edge", int'(slot_vld), 0);
    @(negedge clk);
    bit_vld = 1'b0;
    check_int("R11", "strobe after eighth bit edge", int'(slot_vld), 1);
    check_int("R11", "strobed byte", int'(slot_byte), 8'h5A);
    check_int("R11", "strobed channel", int'(slot_chan), 4);
    @(negedge clk);
    check_int("R11", "strobe lasts one cycle", int'(slot_vld), 0);
    repeat (4) @(negedge clk);

    // random tables and frames (R3 R4 R5 R6 R7 R8)
    for (int it = 0; it < 8; it++) begin
      n_ent = 1 + int'($urandom % 10);
      tot = 0;
      for (int i = 0; i < n_ent; i++) begin
        shadow[i] = mk_ent(codes[$urandom % 7], 3'($urandom), i == n_ent - 1);
        tot += int'(shadow[i][4:2]) + 1;
      end
      sad = 4 * int'($urandom % 4);
      load_rx(sad, n_ent);
      tot += int'($urandom % 3);
      if (tot > 64) tot = 64;
      for (int i = 0; i < tot; i++) fb[i] = 8'($urandom);
      begin
        int dly;
        dly = int'($urandom % 4);
        set_mode(sad, dly, 1'($urandom));
        run_frame("R5", dly, tot, 1'b0);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule